// File: doc/BRIEF.md
# Readout Buffer Occupancy Guard

This block sits in a trigger controller and keeps a cycle-exact count of how many accepted events are waiting in the front-end readout buffers. It runs on the bunch clock, where each cycle can carry one raw first-level accept. An accept passes only when the modelled buffer still has a free slot and no outside throttle is active. Otherwise the accept is turned into a veto, so the real buffers can never overflow. The block stores no event data. It only tracks how many slots are in use and how long the event at the head of the queue has been draining.

Each accepted event takes one slot. Events leave one at a time, in arrival order. An event leaves after a fixed number of readout cycles: by default 36 cycles, which is 32 data words plus 4 tag words, or 900 ns at 40 MHz. The buffer depth is 16 by default. Both values are parameters. When the buffer starts empty, up to the full depth of back-to-back accepts pass with no gap between them. A sticky error flag records any occupancy above the depth.

Top module: `deran_guard`

## Requirements
- R1: After reset, occupancy reads 0, the error flag is low, and neither the passed accept nor the veto is high while the raw accept is low.
- R2: When occupancy is below the depth and the throttle is low, a raw accept leaves in the same cycle on the passed-accept output with no veto. This holds on consecutive cycles, with no gap required.
- R3: When occupancy equals the depth, a raw accept raises the veto, does not pass, and is not counted.
- R4: While the throttle input is high, a raw accept raises the veto, does not pass, and is not counted.
- R5: A passed accept raises occupancy by one on the next cycle when no readout finishes in the same cycle.
- R6: Readout of the head event begins in the cycle after it enters an empty buffer. Readout of the next queued event begins immediately after the previous one ends. Each readout holds its slot for exactly READOUT_CYCLES cycles, and occupancy then drops by one.
- R7: A passed accept in the same cycle as a readout completion leaves occupancy unchanged.
- R8: Occupancy never exceeds the depth. The error flag, which would latch until reset on any such excess, stays low.
- R9: The veto is high only together with a raw accept, and the passed accept and the veto are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Raw first-level accept, one per cycle at most |
| throttle_in | input | 1 | External throttle, ORed into the veto |
| trig_out | output | 1 | Accept passed on to the front end |
| veto | output | 1 | Raw accept refused in this cycle |
| occupancy | output | $clog2(DEPTH+2) | Modelled number of events held |
| ovf_err | output | 1 | Sticky flag: occupancy exceeded the depth |

## Verification
The bench builds the block with a depth of 4 and a readout time of 5 cycles. With these values a burst of accepts fills the buffer within a few cycles, so the full-buffer veto, a drain event by event, and an accept that lands exactly on a readout completion all come up often in a short run. Long random runs with a high accept rate and occasional throttle then keep the buffer near full, so completions and vetoes overlap frequently.

// File: rtl/deran_pkg.sv
package deran_pkg;

    // Occupancy counter width: must hold values up to DEPTH+1 so an excess is visible
    function automatic int occ_bits(input int depth);
        return $clog2(depth + 2);
    endfunction

    // Readout timer width: counts READOUT_CYCLES-1 down to zero
    function automatic int tmr_bits(input int cycles);
        return (cycles < 2) ? 1 : $clog2(cycles);
    endfunction

endpackage

// File: rtl/deran_rdtimer.sv
module deran_rdtimer #(
    parameter int READOUT_CYCLES = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic done
);
    localparam int TW = deran_pkg::tmr_bits(READOUT_CYCLES);
    localparam logic [TW-1:0] RELOAD = TW'(READOUT_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = busy && (s_q.cnt == '0);
        if (!busy || s_q.cnt == '0) begin
            s_d.cnt = RELOAD;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= RELOAD;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a running readout counts down one step per cycle
    a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R6: while idle, the timer waits fully loaded for the next event
    a_r6_idle_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (s_q.cnt == RELOAD));

endmodule

// File: rtl/deran_occ.sv
module deran_occ #(
    parameter int DEPTH = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   accept,
    input  logic                                   drain,
    output logic [deran_pkg::occ_bits(DEPTH)-1:0]  occ,
    output logic                                   full,
    output logic                                   err
);
    localparam int CW = deran_pkg::occ_bits(DEPTH);
    localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] occ;
        logic          err;
    } occ_t;

    occ_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case ({accept, drain})
            2'b10:   s_d.occ = s_q.occ + 1'b1;
            2'b01:   s_d.occ = s_q.occ - 1'b1;
            default: s_d.occ = s_q.occ;
        endcase
        s_d.err = s_q.err | (s_q.occ > DEPTH_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.occ <= '0;
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign occ  = s_q.occ;
    assign full = (s_q.occ == DEPTH_V);
    assign err  = s_q.err;

    // R5: a lone accept adds one slot
    a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !drain) |=> (s_q.occ == $past(s_q.occ) + 1'b1));

    // R7: accept and completion in the same cycle cancel
    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && drain) |=> $stable(s_q.occ));

    // R8: occupancy never goes past the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.occ <= DEPTH_V);

    // R3: no accept reaches the counter while it is full
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !accept);

endmodule

// File: rtl/deran_guard.sv
module deran_guard #(
    parameter int DEPTH          = 16,
    parameter int READOUT_CYCLES = 36
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  trig_in,
    input  logic                                  throttle_in,
    output logic                                  trig_out,
    output logic                                  veto,
    output logic [deran_pkg::occ_bits(DEPTH)-1:0] occupancy,
    output logic                                  ovf_err
);
    localparam int CW = deran_pkg::occ_bits(DEPTH);

    logic          full;
    logic          busy;
    logic          done;
    logic [CW-1:0] occ;

    assign veto      = trig_in && (full || throttle_in);
    assign trig_out  = trig_in && !veto;
    assign busy      = (occ != '0);
    assign occupancy = occ;

    deran_occ #(
        .DEPTH (DEPTH)
    ) u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (trig_out),
        .drain  (done),
        .occ    (occ),
        .full   (full),
        .err    (ovf_err)
    );

    deran_rdtimer #(
        .READOUT_CYCLES (READOUT_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .done  (done)
    );

    // R9: pass and veto are exclusive, and a veto needs a raw accept
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_out && veto) && (veto -> trig_in));

    // R4: throttle refuses every raw accept
    a_r4_throttle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && throttle_in) |-> (veto && !trig_out));

    // R6: a completion always frees a slot that was held
    a_r6_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (occupancy != '0));

    // R8: the sticky error stays clear
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_err);

endmodule

// File: tb/sim_deran_guard.sv
module sim_deran_guard;
    localparam int  DEPTH  = 4;
    localparam int  RC     = 5;
    localparam int  CW     = $clog2(DEPTH + 2);
    localparam time PERIOD = 25ns;
    localparam int  LIMIT  = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          throttle_in = 1'b0;
    logic          trig_out, veto, ovf_err;
    logic [CW-1:0] occupancy;

    int checks = 0;
    int errors = 0;
    int m_occ  = 0;
    int m_cnt  = RC - 1;
    string last_tag = "R1";

    always #(PERIOD / 2) clk = ~clk;

    deran_guard #(.DEPTH(DEPTH), .READOUT_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .throttle_in(throttle_in),
        .trig_out(trig_out), .veto(veto), .occupancy(occupancy), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_veto(input bit t, input bit th, input int occ);
        return t && (occ == DEPTH || th);
    endfunction

    function automatic bit head_done(input int occ, input int cnt);
        return (occ != 0) && (cnt == 0);
    endfunction

    task automatic step(input bit t, input bit th);
        bit ev, acc, dn;
        string vtag;
        @(negedge clk);
        trig_in = t;
        throttle_in = th;
        #1;
        chk(int'(occupancy) == m_occ, last_tag, int'(occupancy), m_occ);
        chk(ovf_err == 1'b0, "R8", int'(ovf_err), 0);
        ev  = exp_veto(t, th, m_occ);
        acc = t && !ev;
        vtag = (t && m_occ == DEPTH) ? "R3" : (t && th) ? "R4" : t ? "R2" : "R9";
        chk(veto == ev, vtag, int'(veto), int'(ev));
        chk(trig_out == acc, vtag, int'(trig_out), int'(acc));
        dn = head_done(m_occ, m_cnt);
        last_tag = (acc && dn) ? "R7" : acc ? "R5" : dn ? "R6" : "R8";
        @(posedge clk);
        m_cnt = (m_occ == 0 || m_cnt == 0) ? RC - 1 : m_cnt - 1;
        m_occ = m_occ + int'(acc) - int'(dn);
    endtask

    initial begin
        #(PERIOD * LIMIT);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(occupancy == '0, "R1", int'(occupancy), 0);
        chk(ovf_err == 1'b0, "R1", int'(ovf_err), 0);
        chk(!trig_out && !veto, "R1", int'(trig_out | veto), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: back-to-back burst from empty, then full veto
        for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 1'b0);
        // R6: drain one event at a time
        for (int i = 0; i < DEPTH * RC + 4; i++) step(1'b0, 1'b0);
        // R7: accept landing on a completion
        step(1'b1, 1'b0);
        for (int i = 0; i < RC - 1; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        // R4: throttle blocks accepts
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 2 * RC; i++) step(1'b0, 1'b0);

        // random traffic with a high accept rate
        for (int i = 0; i < 6000; i++) begin
            bit t, th;
            t  = ($urandom % 100) < 45;
            th = ($urandom % 100) < 8;
            step(t, th);
        end
        for (int i = 0; i < DEPTH * RC + 2; i++) step(1'b0, 1'b0);
        chk(int'(occupancy) == 0, "R6", int'(occupancy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule